// File: doc/BRIEF.md
# Four-Channel Compare-Match PWM Timer

This block is a memory-mapped timer with four independent 16-bit channels. Each channel owns a free-running counter, a control word, a mode word, a pin-control word and four compare registers named A to D. A compare register can act as the counter's clear point, and compare A can act on the channel's output pin. In normal mode, a match on compare A applies a hold, drive-low, drive-high or toggle action to the pin. In PWM mode, compare A sets the edge where the duty ends and a match on compare B returns the pin to its starting level. When compare B is also chosen as the clear source, the period is B+1 count ticks long.

Each channel counts from the system clock divided by 1, 4, 16 or 64. A shared start register holds one run bit per channel. Software reaches every register over a plain 16-bit register bus. A read returns the live contents in the same cycle. A write takes effect at the next clock edge. The bus has no valid/ready pair because it never applies back-pressure: an access is complete in the cycle it is presented. The register file carries no data stream, so the only streaming-style output is the pin vector, which is a plain level output.

Top module: `cmt_pwm_timer`

## Requirements
- R1: After reset, every register reads 0x0000 and every pin is low.
- R2: The start register is at byte address 0x00. Channel n's registers start at 0x10 + 0x40*n, at these local offsets: control 0x00, mode 0x04, pin control 0x08, counter 0x14, and compares A/B/C/D at 0x18/0x1C/0x20/0x24. Each of these registers reads back the full 16-bit value last written to it.
- R3: The local offsets 0x0C and 0x10 always read 0x0000, and writes to them have no effect. Start-register bits 15:4 read as 0.
- R4: A channel's counter and prescaler advance only while start bit n is 1. When the bit is cleared, the counter, the prescaler phase and the pin all hold. When the bit is set again, counting resumes from the held state.
- R5: Control bits 1:0 (p) set the count rate to one tick per 4^p clock edges while the channel runs. A write to the control register restarts the prescale phase. Control bits 4:3 (edge select) are stored but do not change the rate.
- R6: Control bits 7:5 select the clear source: 1 = A, 2 = B, 5 = C, 6 = D. On a tick where the counter equals the selected compare, the counter goes to 0 instead of incrementing. Any other code means there is no clear source.
- R7: With no clear match, the counter wraps from 0xFFFF to 0x0000 on a tick.
- R8: Writing the pin-control register drives the pin to the written bit 2 at that clock edge, whether or not the channel runs.
- R9: In normal mode (mode bits 1:0 not equal to 2), a tick where the counter equals A applies pin-control bits 1:0 to the pin: 0 = hold, 1 = low, 2 = high, 3 = toggle.
- R10: In PWM mode (mode bits 1:0 = 2), a tick where the counter equals A applies the bits 1:0 action. A tick where the counter equals B sets the pin to bit 2. If A and B match on the same tick, B wins.
- R11: Writing compare A while the channel runs changes the duty from the next match onward, without resetting the counter.
- R12: A counter write loads the written value and overrides any tick at the same edge.
- R13: Reads are combinational and show live contents, including the running counter. Writes are visible from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when bus_en is low |
| pwm_out | output | 4 | One output pin per channel |

## Verification
A write lands at the edge that follows its presentation, and a read is valid in the same cycle. The start bit's effect therefore appears at the edge after the start write: that edge is the first tick when the prescaler is 1. The pin is registered, so it changes at the same edge as the counter. The bench drives and samples at falling edges and tracks a tick count t since the start write. It computes the expected counter value as t reduced by the period, and the expected pin from the phase t mod (B+1) against A. The stop write's own edge is counted as one more running edge.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int DW        = 16;
  localparam int REG_OFS_W = 6;
  localparam int NCMP      = 4;
  localparam int PSEL_W    = 2;

  localparam logic [REG_OFS_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [REG_OFS_W-1:0] OFS_MODE = 6'h04;
  localparam logic [REG_OFS_W-1:0] OFS_PCTL = 6'h08;
  localparam logic [REG_OFS_W-1:0] OFS_CNT  = 6'h14;
  localparam logic [REG_OFS_W-1:0] OFS_CMP0 = 6'h18;

  localparam logic [1:0] MODE_PWM = 2'd2;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } pin_act_e;

  function automatic logic [REG_OFS_W-1:0] cmp_ofs(input int idx);
    return REG_OFS_W'(int'(OFS_CMP0) + 4 * idx);
  endfunction

  function automatic logic apply_act(input logic cur, input logic [1:0] code);
    case (pin_act_e'(code))
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = 2 * ((1 << SEL_W) - 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  assign lim  = ~({DIV_W{1'b1}} << {sel, 1'b0});
  assign tick = run && (div_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (run)     div_q <= tick ? '0 : div_q + 1'b1;
  end

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0 && !restart) |=> !tick);
  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(div_q));
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 wr_en,
  input  logic [REG_OFS_W-1:0] loc_addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic                 pin
);
  logic [DW-1:0] ctrl_q, mode_q, pctl_q, cnt_q;
  logic [DW-1:0] cmp_q [NCMP];
  logic [NCMP-1:0] match;
  logic we_ctrl, we_mode, we_pctl, we_cnt;
  logic tick, clr_hit, is_pwm, pin_q, pin_evt;

  assign we_ctrl = wr_en && (loc_addr == OFS_CTRL);
  assign we_mode = wr_en && (loc_addr == OFS_MODE);
  assign we_pctl = wr_en && (loc_addr == OFS_PCTL);
  assign we_cnt  = wr_en && (loc_addr == OFS_CNT);

  cmt_prescaler #(.SEL_W(PSEL_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .restart(we_ctrl),
    .sel    (ctrl_q[PSEL_W-1:0]),
    .tick   (tick)
  );

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    localparam logic [REG_OFS_W-1:0] MY_OFS = cmp_ofs(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cmp_q[g] <= '0;
      else if (wr_en && loc_addr == MY_OFS) cmp_q[g] <= wdata;
    end
    assign match[g] = (cnt_q == cmp_q[g]);
  end

  always_comb begin
    case (ctrl_q[7:5])
      3'd1:    clr_hit = match[0];
      3'd2:    clr_hit = match[1];
      3'd5:    clr_hit = match[2];
      3'd6:    clr_hit = match[3];
      default: clr_hit = 1'b0;
    endcase
  end

  assign is_pwm = (mode_q[1:0] == MODE_PWM);

  always_comb begin
    pin_evt = pin_q;
    if (is_pwm && match[1])  pin_evt = pctl_q[2];
    else if (match[0])       pin_evt = apply_act(pin_q, pctl_q[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      pctl_q <= '0;
      cnt_q  <= '0;
      pin_q  <= 1'b0;
    end else begin
      if (we_ctrl) ctrl_q <= wdata;
      if (we_mode) mode_q <= wdata;
      if (we_pctl) pctl_q <= wdata;
      if (we_cnt)    cnt_q <= wdata;
      else if (tick) cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
      if (we_pctl)   pin_q <= wdata[2];
      else if (tick) pin_q <= pin_evt;
    end
  end

  always_comb begin
    rdata = '0;
    case (loc_addr)
      OFS_CTRL: rdata = ctrl_q;
      OFS_MODE: rdata = mode_q;
      OFS_PCTL: rdata = pctl_q;
      OFS_CNT:  rdata = cnt_q;
      default: begin
        for (int i = 0; i < NCMP; i++)
          if (loc_addr == cmp_ofs(i)) rdata = cmp_q[i];
      end
    endcase
  end

  assign pin = pin_q;

  // R8
  pctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_pctl |=> pin_q == $past(wdata[2]));
  // R4
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !we_cnt) |=> $stable(cnt_q));
  // R4
  pin_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !we_pctl) |=> $stable(pin_q));
  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !we_cnt && cnt_q == 16'hFFFF && !clr_hit) |=> cnt_q == 16'h0000);
  // R10
  pwm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && is_pwm && match[1] && !we_pctl) |=> pin_q == $past(pctl_q[2]));
  // R12
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_cnt |=> cnt_q == $past(wdata));
endmodule

// File: rtl/cmt_pwm_timer.sv
module cmt_pwm_timer
  import cmt_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int ADDR_W  = 8,
  parameter int CH_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W:0]   SPAN_A = (ADDR_W + 1)'(NCH << REG_OFS_W);

  logic [NCH-1:0]       run_q;
  logic [ADDR_W-1:0]    off;
  logic                 in_ch, start_sel, start_we;
  logic [IDX_W-1:0]     ch_idx;
  logic [REG_OFS_W-1:0] loc;
  logic [DW-1:0]        ch_rdata [NCH];

  assign off       = bus_addr - BASE_A;
  assign in_ch     = (bus_addr >= BASE_A) && ({1'b0, off} < SPAN_A);
  assign ch_idx    = IDX_W'(off >> REG_OFS_W);
  assign loc       = off[REG_OFS_W-1:0];
  assign start_sel = (bus_addr == '0);
  assign start_we  = bus_en && bus_wr && start_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (start_we) run_q <= bus_wdata[NCH-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cmt_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q[c]),
      .wr_en   (bus_en && bus_wr && in_ch && (ch_idx == IDX_W'(c))),
      .loc_addr(loc),
      .wdata   (bus_wdata),
      .rdata   (ch_rdata[c]),
      .pin     (pwm_out[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_wr) begin
      if (start_sel)  bus_rdata = DW'(run_q);
      else if (in_ch) bus_rdata = ch_rdata[ch_idx];
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_we |=> run_q == $past(bus_wdata[NCH-1:0]));
  // R13
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> bus_rdata == '0);
endmodule

// File: tb/cmt_pwm_timer_test.sv
module cmt_pwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  pwm_out;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  cmt_pwm_timer uut (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  function automatic logic [7:0] ra(input int ch, input int ofs);
    return 8'(16 + ch * 64 + ofs);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic cfg(input int ch, input logic [15:0] ctrl, mode, pctl, a, b, c, d, cnt);
    wr(ra(ch, 0), ctrl); wr(ra(ch, 4), mode); wr(ra(ch, 8), pctl);
    wr(ra(ch, 24), a); wr(ra(ch, 28), b); wr(ra(ch, 32), c); wr(ra(ch, 36), d);
    wr(ra(ch, 20), cnt);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] v, v0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int ch = 0; ch < 4; ch++)
      for (int o = 0; o <= 36; o += 4) begin
        rd(ra(ch, o), v); chk("R1 reset reg", v, 16'h0000);
      end
    rd(8'h00, v); chk("R1 start reset", v, 16'h0000);
    chk("R1 pins reset", {12'h0, pwm_out}, 16'h0000);

    // R2 / R8 / R12: readback of every register
    for (int ch = 0; ch < 4; ch++) begin
      int ofs [8] = '{0, 4, 8, 20, 24, 28, 32, 36};
      for (int k = 0; k < 8; k++) begin
        logic [15:0] pat;
        pat = 16'(16'hC35A + ch * 16'h1357 + ofs[k] * 16'h0203);
        wr(ra(ch, ofs[k]), pat);
        rd(ra(ch, ofs[k]), v); chk("R2 readback", v, pat);
        if (ofs[k] == 8) chk("R8 pin follows bit2", {15'h0, pwm_out[ch]}, {15'h0, pat[2]});
      end
      // R3: reserved offsets
      wr(ra(ch, 12), 16'hFFFF); rd(ra(ch, 12), v); chk("R3 offset 0x0C", v, 16'h0000);
      wr(ra(ch, 16), 16'hFFFF); rd(ra(ch, 16), v); chk("R3 offset 0x10", v, 16'h0000);
    end
    wr(8'h00, 16'hFFF0); rd(8'h00, v); chk("R3 start upper bits", v, 16'h0000);

    // R5 / R4: prescaler sweep, freeze, resume
    for (int p = 0; p < 4; p++) begin
      int m1, m2;
      m1 = 100 + p * 37; m2 = 50 + p * 11;
      cfg(0, 16'(p | ((p % 3) << 3)), 16'h0, 16'h0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0);
      rd(ra(1, 20), v0);
      wr(8'h00, 16'h1);
      repeat (m1) @(negedge clk);
      wr(8'h00, 16'h0);
      rd(ra(0, 20), v); chk("R5 prescaled count", v, 16'((m1 + 1) >> (2 * p)));
      rd(ra(1, 20), v); chk("R4 idle channel holds", v, v0);
      repeat (20) @(negedge clk);
      rd(ra(0, 20), v); chk("R4 frozen counter", v, 16'((m1 + 1) >> (2 * p)));
      wr(8'h00, 16'h1);
      repeat (m2) @(negedge clk);
      wr(8'h00, 16'h0);
      rd(ra(0, 20), v); chk("R4 resume count", v, 16'((m1 + m2 + 2) >> (2 * p)));
    end

    // R7: wrap
    cfg(0, 16'h0, 16'h0, 16'h0, 16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'hFFFD);
    wr(8'h00, 16'h1); repeat (4) @(negedge clk); wr(8'h00, 16'h0);
    rd(ra(0, 20), v); chk("R7 wrap", v, 16'h0002);

    // R6: clear source codes
    for (int code = 0; code < 8; code++) begin
      int per, expv;
      cfg(2, 16'(code << 5), 16'h0, 16'h0, 16'd4, 16'd6, 16'd8, 16'd10, 16'h0);
      wr(8'h00, 16'h4); repeat (40) @(negedge clk); wr(8'h00, 16'h0);
      case (code)
        1: per = 5; 2: per = 7; 5: per = 9; 6: per = 11; default: per = 0;
      endcase
      expv = (per == 0) ? 41 : 41 % per;
      rd(ra(2, 20), v); chk("R6 clear source", v, 16'(expv));
    end

    // R10: PWM sweep, both polarities, duty 0..7, period 8
    for (int pol = 0; pol < 2; pol++)
      for (int d = 0; d < 8; d++) begin
        logic init;
        init = (pol == 1);
        cfg(3, 16'(2 << 5), 16'h2, pol ? 16'h5 : 16'h2, 16'(d), 16'd7, 16'hFFFF, 16'hFFFF, 16'h0);
        wr(8'h00, 16'h8);
        for (int t = 0; t < 20; t++) begin
          logic e;
          e = ((t % 8) >= d + 1) ? ~init : init;
          chk("R10 pwm pin", {15'h0, pwm_out[3]}, {15'h0, e});
          @(negedge clk);
        end
        wr(8'h00, 16'h0);
      end

    // R11: duty change while running
    cfg(3, 16'(2 << 5), 16'h2, 16'h2, 16'd2, 16'd7, 16'hFFFF, 16'hFFFF, 16'h0);
    wr(8'h00, 16'h8);
    repeat (10) @(negedge clk);
    wr(ra(3, 24), 16'd5);
    rd(ra(3, 20), v); chk("R11 counter not restarted", v, 16'd3);
    for (int t = 11; t < 40; t++) begin
      logic e;
      e = (t < 16) ? 1'b1 : ((t % 8) >= 6);
      chk("R11 new duty", {15'h0, pwm_out[3]}, {15'h0, e});
      @(negedge clk);
    end
    wr(8'h00, 16'h0);

    // R9: normal mode actions, clear on A with A = 3
    for (int code = 0; code < 8; code++) begin
      cfg(1, 16'(1 << 5), 16'h0, 16'(code), 16'd3, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0);
      wr(8'h00, 16'h2);
      for (int t = 0; t < 16; t++) begin
        logic init, e;
        int n;
        init = code[2]; n = t / 4;
        case (code & 3)
          1: e = (n > 0) ? 1'b0 : init;
          2: e = (n > 0) ? 1'b1 : init;
          3: e = init ^ n[0];
          default: e = init;
        endcase
        chk("R9 normal action", {15'h0, pwm_out[1]}, {15'h0, e});
        @(negedge clk);
      end
      wr(8'h00, 16'h0);
    end

    // R4 / R8: stop holds pin, pin-control write forces level
    cfg(3, 16'(2 << 5), 16'h2, 16'h2, 16'd2, 16'd7, 16'hFFFF, 16'hFFFF, 16'h0);
    wr(8'h00, 16'h8);
    repeat (5) @(negedge clk);
    wr(8'h00, 16'h0);
    repeat (20) @(negedge clk);
    chk("R4 pin held while stopped", {15'h0, pwm_out[3]}, 16'h0001);
    rd(ra(3, 20), v); chk("R4 counter held", v, 16'd6);
    wr(ra(3, 8), 16'h0); chk("R8 force low", {15'h0, pwm_out[3]}, 16'h0000);
    wr(ra(3, 8), 16'h4); chk("R8 force high", {15'h0, pwm_out[3]}, 16'h0001);

    // R12 / R13: counter write wins over tick, live reads
    cfg(0, 16'h0, 16'h0, 16'h0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0);
    wr(8'h00, 16'h1);
    repeat (7) @(negedge clk);
    wr(ra(0, 20), 16'h0100);
    rd(ra(0, 20), v); chk("R12 load wins", v, 16'h0100);
    @(negedge clk);
    rd(ra(0, 20), v); chk("R13 live counter", v, 16'h0101);
    wr(8'h00, 16'h0);

    finish_run();
  end
endmodule